// File: doc/BRIEF.md
# Address-Prefixed SPI Chip-Select Demultiplexer

This block listens passively on a shared SPI bus (mode 0) next to one master chip-select line. When the master lowers its select, the block takes the first eight bits the master shifts out on MOSI as a device address. Once that byte is complete, it lowers one of eight active-low downstream selects for the rest of the transaction. All downstream selects return high after the master raises its select.

The upper five address bits must equal a strap input. If they do not, no downstream select is driven for that transaction. Several copies on one bus can therefore each own a distinct block of eight addresses. The master only prepends the address byte to its normal payload. The block has no MISO pin and drives nothing back onto the bus. The bus pins are brought into the system clock domain by two-flop synchronizers, and all edges are detected on the synchronized copies.

Top module: `spi_addr_csdemux`

## Requirements
- R1: After reset all eight `dev_cs_n` outputs are high and `dbg_dev_idx` is 0.
- R2: While `spi_cs_n` is low, the block samples MOSI on rising SCLK edges, MSB first, and the first eight sampled bits form the address.
- R3: When the completed address has bits [7:3] equal to `range_strap`, `dev_cs_n[addr[2:0]]` goes low and the other seven stay high until `spi_cs_n` rises.
- R4: When address bits [7:3] differ from `range_strap`, all `dev_cs_n` stay high for the whole transaction.
- R5: SCLK edges and MOSI bits after the address byte (the payload) change neither the selected output nor `dbg_dev_idx`.
- R6: No `dev_cs_n` goes low before the eighth address bit. A transaction that ends early selects nothing, and the next transaction counts its address from bit zero.
- R7: All `dev_cs_n` are high by the third rising `clk` edge after `spi_cs_n` rises.
- R8: At no time is more than one `dev_cs_n` low.
- R9: `dbg_dev_idx` holds bits [2:0] of the last completed address byte, whether or not it matched the strap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| spi_sclk | input | 1 | Bus serial clock (idle low) |
| spi_mosi | input | 1 | Bus master-out data |
| spi_cs_n | input | 1 | Master chip-select, active low |
| range_strap | input | 5 | Address range owned by this instance (address bits [7:3]) |
| dev_cs_n | output | 8 | Downstream chip-selects, active low |
| dbg_dev_idx | output | 3 | Device index from the last completed address |

## Verification
Every one of the 256 address values is sent under three strap settings. This shows that the decode uses exactly bits [7:3] for the range and bits [2:0], MSB first, for the output. It also separates matching from non-matching ranges at every boundary. In each transaction the selects are checked after seven bits and again after eight, which catches an off-by-one in the bit count. A payload of inverted address bits then follows: if the block kept shifting after the address byte, the selected output would change. An aborted transaction of five bits, followed by a full one, shows that the bit counter restarts when the master deasserts its select.

// File: rtl/spi_csdemux_pkg.sv
package spi_csdemux_pkg;

   // Synchronized view of the three observed bus pins.
   typedef struct packed {
      logic csn;
      logic sclk;
      logic mosi;
   } spi_bus_t;

   localparam int unsigned BUS_W = $bits(spi_bus_t);
   // Idle level: select high, clock low (mode 0), data low.
   localparam logic [BUS_W-1:0] BUS_IDLE = 3'b100;

endpackage

// File: rtl/spi_csdemux_sync.sv
module spi_csdemux_sync #(
   parameter int unsigned W = 3,
   parameter int unsigned STAGES = 2,
   parameter logic [W-1:0] RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("spi_csdemux_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0][W-1:0] stg;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg <= {STAGES{RST_VAL}};
      else        stg <= {stg[STAGES-2:0], d};
   end

   assign q = stg[STAGES-1];

endmodule

// File: rtl/spi_csdemux_shifter.sv
module spi_csdemux_shifter #(
   parameter int unsigned ADDR_W = 8,
   parameter int unsigned IDX_W = 3,
   localparam int unsigned CNT_W = $clog2(ADDR_W + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              csn,
   input  logic              sclk_rise,
   input  logic              mosi,
   output logic [ADDR_W-1:0] addr,
   output logic              done,
   output logic [IDX_W-1:0]  dev_idx
);

   logic [CNT_W-1:0]  cnt;
   logic [ADDR_W-1:0] shreg;
   logic [ADDR_W-1:0] shreg_nxt;
   logic              last_bit;

   assign shreg_nxt = {shreg[ADDR_W-2:0], mosi};
   assign last_bit  = (cnt == CNT_W'(ADDR_W - 1));
   assign done      = (cnt == CNT_W'(ADDR_W));
   assign addr      = shreg;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt     <= '0;
         shreg   <= '0;
         dev_idx <= '0;
      end else if (csn) begin
         cnt   <= '0;
         shreg <= '0;
      end else if (sclk_rise && !done) begin
         shreg <= shreg_nxt;
         cnt   <= cnt + 1'b1;
         if (last_bit) dev_idx <= shreg_nxt[IDX_W-1:0];
      end
   end

   // R2: the bit counter never runs past one address byte
   p_cnt_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= CNT_W'(ADDR_W));

   // R5: once the address is complete, the payload leaves it untouched
   p_addr_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (done && $past(done)) |-> ($stable(shreg) && $stable(dev_idx)));

endmodule

// File: rtl/spi_csdemux_decode.sv
module spi_csdemux_decode #(
   parameter int unsigned ADDR_W = 8,
   parameter int unsigned IDX_W = 3,
   localparam int unsigned NUM_CS = 1 << IDX_W,
   localparam int unsigned RANGE_W = ADDR_W - IDX_W
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               csn,
   input  logic               done,
   input  logic [ADDR_W-1:0]  addr,
   input  logic [RANGE_W-1:0] strap,
   output logic [NUM_CS-1:0]  cs_n
);

   logic              match;
   logic              enable;
   logic [NUM_CS-1:0] hit;

   assign match  = (addr[ADDR_W-1:IDX_W] == strap);
   assign enable = !csn && done && match;

   generate
      for (genvar i = 0; i < NUM_CS; i++) begin : g_out
         assign hit[i] = enable && (addr[IDX_W-1:0] == IDX_W'(i));
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cs_n <= '1;
      else        cs_n <= ~hit;
   end

   // R6: nothing is selected before the address byte is complete
   p_no_early_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !done |=> (&cs_n));

   // R3: a matching address lowers a select on the next cycle
   p_match_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (done && match && !csn) |=> (cs_n != '1));

   // R4: a foreign address leaves every select high
   p_nomatch_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !match) |=> (&cs_n));

endmodule

// File: rtl/spi_addr_csdemux.sv
module spi_addr_csdemux
   import spi_csdemux_pkg::*;
#(
   parameter int unsigned ADDR_W = 8,
   parameter int unsigned IDX_W = 3,
   parameter int unsigned SYNC_STAGES = 2,
   localparam int unsigned NUM_CS = 1 << IDX_W,
   localparam int unsigned RANGE_W = ADDR_W - IDX_W
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               spi_sclk,
   input  logic               spi_mosi,
   input  logic               spi_cs_n,
   input  logic [RANGE_W-1:0] range_strap,
   output logic [NUM_CS-1:0]  dev_cs_n,
   output logic [IDX_W-1:0]   dbg_dev_idx
);

   generate
      if (IDX_W < 1 || IDX_W >= ADDR_W) begin : g_bad_idx
         $error("spi_addr_csdemux: IDX_W must be in 1..ADDR_W-1");
      end
      if (ADDR_W < 2) begin : g_bad_addr
         $error("spi_addr_csdemux: ADDR_W must be at least 2");
      end
   endgenerate

   spi_bus_t          raw;
   spi_bus_t          syn;
   spi_bus_t          syn_d;
   logic [BUS_W-1:0]  syn_vec;
   logic              sclk_rise;
   logic [ADDR_W-1:0] addr;
   logic              done;

   assign raw = '{csn: spi_cs_n, sclk: spi_sclk, mosi: spi_mosi};

   spi_csdemux_sync #(
      .W      (BUS_W),
      .STAGES (SYNC_STAGES),
      .RST_VAL(BUS_IDLE)
   ) u_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .d    (raw),
      .q    (syn_vec)
   );

   assign syn = syn_vec;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) syn_d <= BUS_IDLE;
      else        syn_d <= syn;
   end

   assign sclk_rise = syn.sclk && !syn_d.sclk && !syn.csn;

   spi_csdemux_shifter #(
      .ADDR_W(ADDR_W),
      .IDX_W (IDX_W)
   ) u_shift (
      .clk      (clk),
      .rst_n    (rst_n),
      .csn      (syn.csn),
      .sclk_rise(sclk_rise),
      .mosi     (syn.mosi),
      .addr     (addr),
      .done     (done),
      .dev_idx  (dbg_dev_idx)
   );

   spi_csdemux_decode #(
      .ADDR_W(ADDR_W),
      .IDX_W (IDX_W)
   ) u_dec (
      .clk  (clk),
      .rst_n(rst_n),
      .csn  (syn.csn),
      .done (done),
      .addr (addr),
      .strap(range_strap),
      .cs_n (dev_cs_n)
   );

   // R8: at most one downstream select is active
   p_onehot_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(~dev_cs_n));

   // R7: a synchronized master release clears every select next cycle
   p_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
      syn.csn |=> (&dev_cs_n));

endmodule

// File: tb/tb_spi_addr_csdemux.sv
module tb_spi_addr_csdemux;

   localparam int HALF = 3;
   localparam int WATCHDOG = 190000;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       sclk = 1'b0;
   logic       mosi = 1'b0;
   logic       csn = 1'b1;
   logic [4:0] strap = '0;
   logic [7:0] cs_n;
   logic [2:0] idx;

   int tests = 0;
   int fails = 0;
   int cycles = 0;

   always #5 clk = ~clk;

   spi_addr_csdemux dut (
      .clk(clk), .rst_n(rst_n), .spi_sclk(sclk), .spi_mosi(mosi),
      .spi_cs_n(csn), .range_strap(strap), .dev_cs_n(cs_n),
      .dbg_dev_idx(idx)
   );

   always @(posedge clk) begin
      cycles <= cycles + 1;
      if (cycles > WATCHDOG) begin
         fails = fails + 1;
         $display("FAIL watchdog: run did not end, actual %0d cycles expected < %0d",
                  cycles, WATCHDOG);
         $display("[TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

   task automatic check(input bit ok, input string req, input int act, input int exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   task automatic wait_n(input int n);
      for (int k = 0; k < n; k++) @(negedge clk);
   endtask

   task automatic send_bits(input logic [7:0] v, input int nbits);
      for (int b = 7; b > 7 - nbits; b--) begin
         @(negedge clk);
         mosi = v[b];
         wait_n(HALF);
         sclk = 1'b1;
         wait_n(HALF);
         sclk = 1'b0;
      end
   endtask

   function automatic logic [7:0] exp_cs(input logic [7:0] a, input logic [4:0] s);
      return (a[7:3] == s) ? ~(8'h01 << a[2:0]) : 8'hFF;
   endfunction

   task automatic transaction(input logic [7:0] a);
      logic [7:0] e;
      e = exp_cs(a, strap);
      @(negedge clk);
      csn = 1'b0;
      wait_n(HALF);
      send_bits(a, 7);
      wait_n(4);
      check(cs_n == 8'hFF, "R6 before eighth bit", cs_n, 8'hFF);
      send_bits({a[0], 7'b0}, 1);
      wait_n(4);
      if (a[7:3] == strap)
         check(cs_n == e, "R3 match select", cs_n, e);
      else
         check(cs_n == e, "R4 foreign range", cs_n, e);
      check(idx == a[2:0], "R9 index latch", idx, a[2:0]);
      check($countones(~cs_n) <= 1, "R8 single select", cs_n, e);
      send_bits(~a, 4);
      wait_n(2);
      check(cs_n == e && idx == a[2:0], "R5 payload ignored", {idx, cs_n}, {a[2:0], e});
      @(negedge clk);
      csn = 1'b1;
      wait_n(3);
      check(cs_n == 8'hFF, "R7 release", cs_n, 8'hFF);
      wait_n(2);
   endtask

   initial begin
      logic [4:0] straps [3];
      straps[0] = 5'd0;
      straps[1] = 5'd13;
      straps[2] = 5'd31;
      wait_n(3);
      check(cs_n == 8'hFF, "R1 reset selects", cs_n, 8'hFF);
      check(idx == 3'd0, "R1 reset index", idx, 0);
      rst_n = 1'b1;
      wait_n(3);

      // R2: full sweep of address values and strap settings
      for (int s = 0; s < 3; s++) begin
         strap = straps[s];
         for (int a = 0; a < 256; a++) transaction(8'(a));
      end

      // R6: aborted transaction, then a fresh one restarts the count
      strap = 5'd13;
      @(negedge clk);
      csn = 1'b0;
      wait_n(HALF);
      send_bits(8'h6D, 5);
      wait_n(4);
      check(cs_n == 8'hFF, "R6 aborted no select", cs_n, 8'hFF);
      @(negedge clk);
      csn = 1'b1;
      wait_n(6);
      check(cs_n == 8'hFF, "R6 aborted stays idle", cs_n, 8'hFF);
      transaction(8'h6A);

      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

endmodule